// File: doc/BRIEF.md
# Counter Event Flag Generator

This block is one channel of a position or event counter. A 25-bit up/down count register advances on pre-decoded count-up and count-down strobes. A single active-high flag output tells the channel's interrupt logic that something of interest happened. A small control register picks which condition drives the flag. The choices are:

- the count wrapping past its top value;
- the count stepping onto a stored preset value;
- the count wrapping in either direction;
- a rising edge on the index input.

The same register also gates counting and can make an index edge reload the count from the preset.

Software-side logic writes the control register and the 24-bit preset through simple write strobes. A separate direct-load port places a 24-bit value into the count. Only the lower 24 bits of the count can be loaded; the top bit is cleared by every load. Each event is reported as a single-cycle pulse in the cycle after the clock edge that registers it.

Top module: `evflag_counter`

## Requirements
- R1: A synchronous reset clears the count, the preset, the control register (so the function select is 0, wrap-up) and the flag.
- R2: While the control enable bit is clear, the up and down strobes leave the count unchanged and no wrap-up, wrap-down or preset-match event is produced.
- R3: With enable set, a lone up strobe adds one to the count and a lone down strobe subtracts one, modulo 2^25. Both strobes together, or neither, hold the count.
- R4: A direct-load write places the 24-bit value in the count with the top bit cleared. It takes priority over an index reload and over counting in the same cycle.
- R5: With function select 0, the flag pulses only when an enabled up step moves the count from all ones to zero.
- R6: With function select 1, the flag pulses when an enabled up or down step lands the count on the preset value (zero-extended). Loads never produce this event.
- R7: With function select 2, the flag pulses on an up step from all ones to zero and on a down step from zero to all ones.
- R8: With function select 3, the flag pulses on each rising edge of the index input, whether or not counting is enabled.
- R9: When the reload-on-index bit is set, a rising edge of the index input loads the preset value into the count (top bit cleared). This load wins over counting in the same cycle.
- R10: The flag is high for exactly one cycle per event. It is high in the cycle after the clock edge at which the event is registered, even if the cause is held.
- R11: Control word layout: bit 0 is count enable, bit 1 is reload-on-index, bits 4:3 are the function select (0 wrap-up, 1 preset match, 2 wrap-either, 3 index). All other bits are ignored. A new control word takes effect from the cycle after its write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_up | input | 1 | Decoded count-up strobe |
| cnt_dn | input | 1 | Decoded count-down strobe |
| idx_in | input | 1 | Index input, active high |
| load_wr | input | 1 | Direct count load strobe |
| load_din | input | LOAD_W (24) | Value for direct count load |
| preset_wr | input | 1 | Preset register write strobe |
| preset_din | input | LOAD_W (24) | Preset register write data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_din | input | CTL_W (8) | Control register write data |
| count_q | output | CNT_W (25) | Current count |
| evt_flag | output | 1 | Single-cycle event pulse |

## Verification
The properties assume that every input is free of unknowns after reset and changes only between active clock edges. They also assume that the index input is level-sampled, so a rising edge means low in one cycle and high in the next. The bench meets these assumptions by driving on the falling edge and by only ever writing values that fit the 24-bit load and preset fields. Random loads are biased towards zero, one and the 24-bit maximum, and presets are kept small, so that wrap and match events occur often. Index toggling and control rewrites are kept sparse, so the selected source stays in place long enough to fire.

// File: rtl/evf_pkg.sv
`timescale 1ns/1ps
package evf_pkg;

   typedef enum logic [1:0] {
      FS_WRAP_UP   = 2'd0,
      FS_MATCH     = 2'd1,
      FS_WRAP_BOTH = 2'd2,
      FS_INDEX     = 2'd3
   } evf_fsel_e;

   typedef struct packed {
      evf_fsel_e fsel;
      logic      pren;
      logic      en;
   } evf_ctl_t;

   // Bit positions within the control write word
   localparam int unsigned CB_EN      = 0;
   localparam int unsigned CB_PREN    = 1;
   localparam int unsigned CB_FSEL_LO = 3;
   localparam int unsigned CB_FSEL_HI = 4;

endpackage

// File: rtl/evf_ctl_reg.sv
`timescale 1ns/1ps
module evf_ctl_reg
   import evf_pkg::*;
#(
   parameter int unsigned LOAD_W = 24,
   parameter int unsigned CTL_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_din,
   input  logic              preset_wr,
   input  logic [LOAD_W-1:0] preset_din,
   output evf_ctl_t          ctl_q,
   output logic [LOAD_W-1:0] preset_q
);

   evf_ctl_t ctl_d;

   // Only the defined fields are captured; spare bits are dropped
   always_comb begin
      ctl_d.en   = ctl_din[CB_EN];
      ctl_d.pren = ctl_din[CB_PREN];
      ctl_d.fsel = evf_fsel_e'(ctl_din[CB_FSEL_HI:CB_FSEL_LO]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q    <= '0;
         preset_q <= '0;
      end else begin
         if (ctl_wr)    ctl_q    <= ctl_d;
         if (preset_wr) preset_q <= preset_din;
      end
   end

endmodule

// File: rtl/evf_count_core.sv
`timescale 1ns/1ps
module evf_count_core #(
   parameter int unsigned CNT_W  = 25,
   parameter int unsigned LOAD_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              pren,
   input  logic              up,
   input  logic              dn,
   input  logic              idx_in,
   input  logic              load_wr,
   input  logic [LOAD_W-1:0] load_din,
   input  logic [LOAD_W-1:0] preset,
   output logic [CNT_W-1:0]  count_q,
   output logic              carry_n,
   output logic              borrow_n,
   output logic              match,
   output logic              idx_rise,
   output logic              idx_prev
);

   localparam int unsigned     PAD_W   = CNT_W - LOAD_W;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             idx_load;
   logic             step_up;
   logic             step_dn;
   logic [CNT_W-1:0] preset_ext;
   logic [CNT_W-1:0] load_ext;
   logic [CNT_W-1:0] count_d;

   assign preset_ext = {{PAD_W{1'b0}}, preset};
   assign load_ext   = {{PAD_W{1'b0}}, load_din};
   assign idx_rise   = idx_in & ~idx_prev;
   assign idx_load   = pren & idx_rise;

   // Counting only when nothing of higher priority loads the register
   assign step_up = en & up & ~dn & ~load_wr & ~idx_load;
   assign step_dn = en & dn & ~up & ~load_wr & ~idx_load;

   always_comb begin
      if (load_wr)       count_d = load_ext;
      else if (idx_load) count_d = preset_ext;
      else if (step_up)  count_d = count_q + CNT_ONE;
      else if (step_dn)  count_d = count_q - CNT_ONE;
      else               count_d = count_q;
   end

   // Wrap conditions are kept active-low internally
   assign carry_n  = ~(step_up & (count_q == CNT_MAX));
   assign borrow_n = ~(step_dn & (count_q == '0));
   assign match    = (step_up | step_dn) & (count_d == preset_ext);

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q  <= '0;
         idx_prev <= 1'b0;
      end else begin
         count_q  <= count_d;
         idx_prev <= idx_in;
      end
   end

endmodule

// File: rtl/evf_flag_sel.sv
`timescale 1ns/1ps
module evf_flag_sel
   import evf_pkg::*;
#(
   parameter bit EVT_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst,
   input  evf_fsel_e fsel,
   input  logic      carry_n,
   input  logic      borrow_n,
   input  logic      match,
   input  logic      idx_rise,
   output logic      evt
);

   logic src;

   always_comb begin
      unique case (fsel)
         FS_WRAP_UP:   src = ~carry_n;
         FS_MATCH:     src = match;
         FS_WRAP_BOTH: src = ~carry_n | ~borrow_n;
         FS_INDEX:     src = idx_rise;
         default:      src = 1'b0;
      endcase
   end

   generate
      if (EVT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) evt <= 1'b0;
            else     evt <= src;
         end
      end else begin : g_comb
         assign evt = src;
      end
   endgenerate

endmodule

// File: rtl/evflag_counter.sv
`timescale 1ns/1ps
module evflag_counter
   import evf_pkg::*;
#(
   parameter int unsigned CNT_W   = 25,
   parameter int unsigned LOAD_W  = 24,
   parameter int unsigned CTL_W   = 8,
   parameter bit          EVT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cnt_up,
   input  logic              cnt_dn,
   input  logic              idx_in,
   input  logic              load_wr,
   input  logic [LOAD_W-1:0] load_din,
   input  logic              preset_wr,
   input  logic [LOAD_W-1:0] preset_din,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_din,
   output logic [CNT_W-1:0]  count_q,
   output logic              evt_flag
);

   generate
      if (LOAD_W >= CNT_W) begin : g_bad_load
         $error("LOAD_W must be narrower than CNT_W");
      end
      if (CTL_W <= CB_FSEL_HI) begin : g_bad_ctl
         $error("CTL_W too narrow for the function select field");
      end
   endgenerate

   evf_ctl_t          ctl;
   logic [LOAD_W-1:0] preset_q;
   logic              ctl_en;
   logic              ctl_pren;
   logic [1:0]        ctl_fsel;
   logic              carry_n;
   logic              borrow_n;
   logic              match;
   logic              idx_rise;
   logic              idx_prev;

   assign ctl_en   = ctl.en;
   assign ctl_pren = ctl.pren;
   assign ctl_fsel = ctl.fsel;

   evf_ctl_reg #(.LOAD_W(LOAD_W), .CTL_W(CTL_W)) u_ctl (
      .clk        (clk),
      .rst        (rst),
      .ctl_wr     (ctl_wr),
      .ctl_din    (ctl_din),
      .preset_wr  (preset_wr),
      .preset_din (preset_din),
      .ctl_q      (ctl),
      .preset_q   (preset_q)
   );

   evf_count_core #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .en       (ctl_en),
      .pren     (ctl_pren),
      .up       (cnt_up),
      .dn       (cnt_dn),
      .idx_in   (idx_in),
      .load_wr  (load_wr),
      .load_din (load_din),
      .preset   (preset_q),
      .count_q  (count_q),
      .carry_n  (carry_n),
      .borrow_n (borrow_n),
      .match    (match),
      .idx_rise (idx_rise),
      .idx_prev (idx_prev)
   );

   evf_flag_sel #(.EVT_REG(EVT_REG)) u_sel (
      .clk      (clk),
      .rst      (rst),
      .fsel     (ctl.fsel),
      .carry_n  (carry_n),
      .borrow_n (borrow_n),
      .match    (match),
      .idx_rise (idx_rise),
      .evt      (evt_flag)
   );

endmodule

// File: rtl/evf_checks.sv
`timescale 1ns/1ps
module evf_checks #(
   parameter int unsigned CNT_W   = 25,
   parameter int unsigned LOAD_W  = 24,
   parameter bit          EVT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              cnt_up,
   input logic              cnt_dn,
   input logic              idx_in,
   input logic              load_wr,
   input logic [LOAD_W-1:0] load_din,
   input logic [CNT_W-1:0]  count_q,
   input logic              evt_flag,
   input logic              ctl_en,
   input logic              ctl_pren,
   input logic [1:0]        ctl_fsel,
   input logic [LOAD_W-1:0] preset_q,
   input logic              idx_prev
);

   localparam int unsigned PAD_W = CNT_W - LOAD_W;

   logic idx_ld;
   assign idx_ld = ctl_pren & idx_in & ~idx_prev;

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (count_q == '0));

   p_hold_disabled_r2: assert property (@(posedge clk) disable iff (rst)
      (!ctl_en && !load_wr && !idx_ld) |=> $stable(count_q));

   p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
      (ctl_en && cnt_up && !cnt_dn && !load_wr && !idx_ld)
      |=> (count_q == $past(count_q) + 1'b1));

   p_direct_load_r4: assert property (@(posedge clk) disable iff (rst)
      load_wr |=> (count_q == {{PAD_W{1'b0}}, $past(load_din)}));

   p_index_reload_r9: assert property (@(posedge clk) disable iff (rst)
      (idx_ld && !load_wr) |=> (count_q == {{PAD_W{1'b0}}, $past(preset_q)}));

   generate
      if (EVT_REG) begin : g_evt
         p_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
            (ctl_fsel == 2'd0 && ctl_en && cnt_up && !cnt_dn && !load_wr
             && !idx_ld && count_q == {CNT_W{1'b1}}) |=> evt_flag);

         p_index_evt_r8: assert property (@(posedge clk) disable iff (rst)
            (ctl_fsel == 2'd3 && idx_in && !idx_prev) |=> evt_flag);

         p_quiet_disabled_r2: assert property (@(posedge clk) disable iff (rst)
            (!ctl_en && ctl_fsel != 2'd3) |=> !evt_flag);

         p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
            (ctl_fsel == 2'd3 && idx_in && idx_prev) |=> !evt_flag);
      end
   endgenerate

endmodule

bind evflag_counter evf_checks #(
   .CNT_W   (CNT_W),
   .LOAD_W  (LOAD_W),
   .EVT_REG (EVT_REG)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cnt_up   (cnt_up),
   .cnt_dn   (cnt_dn),
   .idx_in   (idx_in),
   .load_wr  (load_wr),
   .load_din (load_din),
   .count_q  (count_q),
   .evt_flag (evt_flag),
   .ctl_en   (ctl_en),
   .ctl_pren (ctl_pren),
   .ctl_fsel (ctl_fsel),
   .preset_q (preset_q),
   .idx_prev (idx_prev)
);

// File: tb/sim_evflag_counter.sv
`timescale 1ns/1ps
module sim_evflag_counter;

   localparam logic [24:0] MAXV = 25'h1FFFFFF;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cnt_up = 0, cnt_dn = 0, idx_in = 0;
   logic        load_wr = 0, preset_wr = 0, ctl_wr = 0;
   logic [23:0] load_din = '0, preset_din = '0;
   logic [7:0]  ctl_din = '0;
   logic [24:0] count_q;
   logic        evt_flag;

   int unsigned total = 0;
   int unsigned bad   = 0;
   bit          done  = 0;

   // Reference state
   logic [24:0] m_cnt;
   logic [23:0] m_pre;
   logic        m_en, m_pren, m_idxd, m_flag;
   logic [1:0]  m_sel;

   always #2.5 clk = ~clk;

   evflag_counter u0 (
      .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .idx_in(idx_in),
      .load_wr(load_wr), .load_din(load_din), .preset_wr(preset_wr),
      .preset_din(preset_din), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
      .count_q(count_q), .evt_flag(evt_flag)
   );

   task automatic chk(input string tg, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
      end
   endtask

   function automatic string sel_tag(input logic [1:0] s);
      case (s)
         2'd0: return "R5";
         2'd1: return "R6";
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   // Reference next-state from the requirements
   task automatic model_step();
      logic rise, ild, su, sd, car, bor, cmp;
      logic [24:0] nxt;
      rise = idx_in & ~m_idxd;
      ild  = m_pren & rise;
      su   = m_en & cnt_up & ~cnt_dn;
      sd   = m_en & cnt_dn & ~cnt_up;
      car = 0; bor = 0; cmp = 0;
      nxt = m_cnt;
      if (load_wr)  nxt = {1'b0, load_din};
      else if (ild) nxt = {1'b0, m_pre};
      else if (su) begin nxt = m_cnt + 25'd1; car = (m_cnt == MAXV); cmp = (nxt == {1'b0, m_pre}); end
      else if (sd) begin nxt = m_cnt - 25'd1; bor = (m_cnt == 25'd0); cmp = (nxt == {1'b0, m_pre}); end
      case (m_sel)
         2'd0: m_flag = car;
         2'd1: m_flag = cmp;
         2'd2: m_flag = car | bor;
         default: m_flag = rise;
      endcase
      m_cnt  = nxt;
      m_idxd = idx_in;
      if (preset_wr) m_pre = preset_din;
      if (ctl_wr) begin
         m_en = ctl_din[0]; m_pren = ctl_din[1]; m_sel = ctl_din[4:3];
      end
   endtask

   task automatic cyc(input logic up, input logic dn, input logic idx,
                      input logic lw, input logic [23:0] ld,
                      input logic pw, input logic [23:0] pd,
                      input logic cw, input logic [7:0] cd,
                      input string tc, input string tf);
      cnt_up = up; cnt_dn = dn; idx_in = idx;
      load_wr = lw; load_din = ld; preset_wr = pw; preset_din = pd;
      ctl_wr = cw; ctl_din = cd;
      model_step();
      @(negedge clk);
      chk(tc, "count", {7'd0, count_q}, {7'd0, m_cnt});
      chk(tf, "flag", {31'd0, evt_flag}, {31'd0, m_flag});
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      cyc(0, 0, idx_in, 0, '0, 0, '0, 1, v, "R11", "R11");
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5eed));
      m_cnt = 0; m_pre = 0; m_en = 0; m_pren = 0; m_sel = 0; m_idxd = 0; m_flag = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1", "count", {7'd0, count_q}, 32'd0);
      chk("R1", "flag", {31'd0, evt_flag}, 32'd0);

      // R2: disabled counting ignores strobes, wrap-up select idle
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R2", "R2");
      cyc(0, 1, 0, 0, '0, 0, '0, 0, '0, "R2", "R2");
      chk("R2", "count held", {7'd0, count_q}, 32'd0);

      // R11: spare bits set, enable clear, reload-on-index set
      wr_ctl(8'hE6);
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R11", "R11");
      chk("R11", "spare bits ignored", {7'd0, count_q}, 32'd0);

      // R4: direct load, and load beats counting
      wr_ctl(8'h01);
      cyc(0, 0, 0, 1, 24'hABCDEF, 0, '0, 0, '0, "R4", "R4");
      chk("R4", "load value", {7'd0, count_q}, 32'h00ABCDEF);
      cyc(1, 0, 0, 1, 24'hFFFFFF, 0, '0, 0, '0, "R4", "R4");
      chk("R4", "load priority", {7'd0, count_q}, 32'h00FFFFFF);
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R3", "R5");
      chk("R3", "25-bit carry into top", {7'd0, count_q}, 32'h01000000);
      cyc(1, 1, 0, 0, '0, 0, '0, 0, '0, "R3", "R5");

      // R7: wrap both ways with select 2
      wr_ctl(8'h11);
      cyc(0, 0, 0, 1, 24'd0, 0, '0, 0, '0, "R4", "R7");
      cyc(0, 1, 0, 0, '0, 0, '0, 0, '0, "R3", "R7");
      chk("R7", "borrow pulse", {31'd0, evt_flag}, 32'd1);
      chk("R3", "wrap down", {7'd0, count_q}, {7'd0, MAXV});
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R3", "R7");
      chk("R7", "carry pulse", {31'd0, evt_flag}, 32'd1);

      // R5: select 0 ignores borrow, reports carry
      wr_ctl(8'h01);
      cyc(0, 1, 0, 0, '0, 0, '0, 0, '0, "R3", "R5");
      chk("R5", "no borrow pulse", {31'd0, evt_flag}, 32'd0);
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R3", "R5");
      chk("R5", "carry pulse", {31'd0, evt_flag}, 32'd1);
      cyc(0, 0, 0, 0, '0, 0, '0, 0, '0, "R10", "R10");

      // R6: preset match from either direction
      wr_ctl(8'h09);
      cyc(0, 0, 0, 1, 24'd3, 1, 24'd5, 0, '0, "R4", "R6");
      chk("R6", "load gives no match", {31'd0, evt_flag}, 32'd0);
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R3", "R6");
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R3", "R6");
      chk("R6", "match up", {31'd0, evt_flag}, 32'd1);
      cyc(1, 0, 0, 0, '0, 0, '0, 0, '0, "R3", "R6");
      cyc(0, 1, 0, 0, '0, 0, '0, 0, '0, "R3", "R6");
      chk("R6", "match down", {31'd0, evt_flag}, 32'd1);

      // R8/R10: index edge, held high gives one pulse
      wr_ctl(8'h18);
      cyc(0, 0, 1, 0, '0, 0, '0, 0, '0, "R8", "R8");
      chk("R8", "index pulse while disabled", {31'd0, evt_flag}, 32'd1);
      cyc(0, 0, 1, 0, '0, 0, '0, 0, '0, "R10", "R10");
      chk("R10", "single pulse", {31'd0, evt_flag}, 32'd0);
      cyc(0, 0, 0, 0, '0, 0, '0, 0, '0, "R10", "R10");

      // R9: reload on index beats counting
      wr_ctl(8'h1B);
      cyc(0, 0, 0, 0, '0, 1, 24'h123456, 0, '0, "R9", "R8");
      cyc(1, 0, 1, 0, '0, 0, '0, 0, '0, "R9", "R8");
      chk("R9", "preset reload", {7'd0, count_q}, 32'h00123456);
      cyc(0, 0, 0, 0, '0, 0, '0, 0, '0, "R9", "R8");
      cyc(0, 0, 1, 1, 24'h000777, 0, '0, 0, '0, "R4", "R8");
      chk("R4", "load beats reload", {7'd0, count_q}, 32'h00000777);

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         logic u, d, ix, lw, pw, cw;
         logic [23:0] ld, pd;
         logic [7:0] cd;
         int unsigned r;
         u  = ($urandom % 3) != 0;
         d  = ($urandom % 3) == 0;
         ix = (($urandom % 8) == 0) ? ~idx_in : idx_in;
         lw = ($urandom % 24) == 0;
         r  = $urandom % 4;
         ld = (r == 0) ? 24'd0 : (r == 1) ? 24'hFFFFFF : (r == 2) ? 24'd1 : 24'($urandom % 8);
         pw = ($urandom % 24) == 0;
         pd = 24'($urandom % 8);
         cw = ($urandom % 48) == 0;
         cd = 8'($urandom);
         if (($urandom % 8) != 0) cd[0] = 1'b1;
         cyc(u, d, ix, lw, ld, pw, pd, cw, cd, "R3", sel_tag(m_sel));
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule